// File: doc/BRIEF.md
# Filtered Fault Shutdown for Three-Phase and PFC Gate Drives

This block sits between a three-phase PWM generator and the gate-driver pins of a motor inverter, plus a single power-factor-correction (PFC) switch. Each fault input passes through a synchronizer and a digital persistence filter. A fault is qualified only after it has been seen on a programmable number of consecutive clocks. A qualified fault is latched and forces the protected outputs to their configured off level. The latch is released only by a clear command that arrives while the filtered fault is no longer present.

Each fault input has its own programmable sense. Each gate pin has its own programmable active level, so "off" means the configured inactive level of that pin. The two switches of a phase are never driven on together, whatever the PWM generator requests. A routing option lets the motor fault input also shut down the PFC output; in that mode the dedicated PFC fault pin is ignored.

Top module: `gk_shutdown`

## Requirements
- R1: Fault sense: when `m_sense` (or `p_sense`) is 1, a high level on the matching fault pin is a fault; when it is 0, a low level is a fault.
- R2: Filtering: let N be `filt_len`, with 0 treated as 1. A fault pulse sampled asserted on at least N consecutive rising clock edges latches the fault. A pulse sampled on fewer than N edges leaves the latch at 0.
- R3: Latency: when a fault pin is asserted and held, its latched status and the forced outputs appear exactly N+3 rising edges after the first edge that samples the asserted level.
- R4: While `m_fault_latched` is 1, every bit of `pwm_gate` equals the inverse of the matching bit of `out_pol`, whatever `pwm_raw` is.
- R5: Output polarity: bit 2k of `pwm_raw` requests the high-side switch of phase k, and bit 2k+1 requests the low-side switch. With no fault latched and no conflict in that phase, `pwm_gate[i]` equals `out_pol[i]` when `pwm_raw[i]` is 1, and equals `~out_pol[i]` when it is 0.
- R6: Shoot-through guard: if both switches of a phase are requested at once, both pins of that phase go to their inactive level. No phase ever shows both pins at their active level.
- R7: A latched fault stays latched after the fault pin returns to idle, until a clear. A clear issued while the filtered fault is still present has no effect.
- R8: A one-cycle `fault_clr`, issued once the pin has been idle for at least 5 clocks, drops both latched statuses at the next rising edge.
- R9: With `pfc_route_main` at 0, the PFC fault pin latches `p_fault_latched` and forces `pfc_gate` to `~pfc_pol`. A motor fault in this mode leaves `p_fault_latched` at 0. With no PFC fault latched, `pfc_gate` equals `pfc_raw ? pfc_pol : ~pfc_pol`.
- R10: With `pfc_route_main` at 1, a qualified motor fault latches `p_fault_latched` and shuts down `pfc_gate`, and the PFC fault pin is ignored.
- R11: After reset, both latched statuses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_fault_pin | input | 1 | Motor fault input |
| m_sense | input | 1 | Motor fault sense (1 = active high) |
| p_fault_pin | input | 1 | PFC fault input |
| p_sense | input | 1 | PFC fault sense (1 = active high) |
| filt_len | input | CNT_W | Consecutive clocks needed to qualify a fault (0 acts as 1) |
| pfc_route_main | input | 1 | 1 = motor fault drives the PFC shutdown, PFC pin ignored |
| pwm_raw | input | 6 | Requested switch states, bit 2k high side / 2k+1 low side of phase k |
| out_pol | input | 6 | Active level per motor gate pin |
| pfc_raw | input | 1 | Requested PFC switch state |
| pfc_pol | input | 1 | Active level of the PFC gate pin |
| fault_clr | input | 1 | Clear command for the latched faults |
| pwm_gate | output | 6 | Motor gate pins |
| pfc_gate | output | 1 | PFC gate pin |
| m_fault_latched | output | 1 | Motor fault latched |
| p_fault_latched | output | 1 | PFC channel fault latched |

## Verification
The hardest condition to reach from the ports is a fault pulse that lasts exactly one clock less than, or exactly as long as, the filter length. The bench sets the pin on a falling edge and counts rising edges, so it knows exactly how many samples the synchronizer sees. It sweeps the pulse length across the threshold for several filter lengths and both senses. A second situation is a clear issued while the fault is still held. The bench keeps the pin asserted through the clear, then releases it, waits until the filter has drained, and checks that a second clear is accepted.

// File: rtl/gk_pkg.sv
package gk_pkg;
  typedef enum logic {
    SENSE_LOW  = 1'b0,
    SENSE_HIGH = 1'b1
  } sense_e;

  // Pin level for a requested switch state under a given active level.
  function automatic logic drive_level(input logic on, input logic act_lvl);
    return on ? act_lvl : ~act_lvl;
  endfunction
endpackage

// File: rtl/gk_filter.sv
module gk_filter #(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             sense,
  input  logic [CNT_W-1:0] thresh,
  output logic             qual
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, limit;
  logic              hit;

  always_comb begin
    limit  = (thresh == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : thresh;
    sync_d = {sync_q[SYNC_N-2:0], (pin ~^ sense)};
    hit    = sync_q[SYNC_N-1];
    cnt_d  = cnt_q;
    if (!hit)
      cnt_d = '0;
    else if (cnt_q < limit)
      cnt_d = cnt_q + 1'b1;
    qual   = (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/gk_latch.sv
module gk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic held_o
);
  logic held_d;

  always_comb begin
    held_d = held_o;
    if (set_i)
      held_d = 1'b1;
    else if (clr_i)
      held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_o <= 1'b0;
    else        held_o <= held_d;
  end
endmodule

// File: rtl/gk_gate.sv
module gk_gate
  import gk_pkg::*;
#(
  parameter int NCH    = 6,
  parameter bit PAIRED = 1'b1
) (
  input  logic [NCH-1:0] raw,
  input  logic [NCH-1:0] act_lvl,
  input  logic           kill,
  output logic [NCH-1:0] pin_out
);
  logic [NCH-1:0] on_req;

  generate
    if (PAIRED) begin : g_paired
      localparam int NPH = NCH / 2;
      for (genvar p = 0; p < NPH; p++) begin : g_ph
        logic clash;
        always_comb begin
          clash           = raw[2*p] & raw[2*p+1];
          on_req[2*p]     = raw[2*p]   & ~clash & ~kill;
          on_req[2*p+1]   = raw[2*p+1] & ~clash & ~kill;
        end
      end
    end else begin : g_single
      always_comb on_req = raw & {NCH{~kill}};
    end
  endgenerate

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_drv
      always_comb pin_out[i] = drive_level(on_req[i], act_lvl[i]);
    end
  endgenerate
endmodule

// File: rtl/gk_shutdown.sv
module gk_shutdown #(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2,
  parameter int NPH    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_fault_pin,
  input  logic             m_sense,
  input  logic             p_fault_pin,
  input  logic             p_sense,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             pfc_route_main,
  input  logic [2*NPH-1:0] pwm_raw,
  input  logic [2*NPH-1:0] out_pol,
  input  logic             pfc_raw,
  input  logic             pfc_pol,
  input  logic             fault_clr,
  output logic [2*NPH-1:0] pwm_gate,
  output logic             pfc_gate,
  output logic             m_fault_latched,
  output logic             p_fault_latched
);
  localparam int NOUT = 2 * NPH;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       m_qual, p_qual, p_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gk_filter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_mfilt (
    .clk(clk), .rst_n(rst_int_n), .pin(m_fault_pin), .sense(m_sense),
    .thresh(filt_len), .qual(m_qual));

  gk_filter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_pfilt (
    .clk(clk), .rst_n(rst_int_n), .pin(p_fault_pin), .sense(p_sense),
    .thresh(filt_len), .qual(p_qual));

  assign p_src = pfc_route_main ? m_qual : p_qual;

  gk_latch u_mlatch (
    .clk(clk), .rst_n(rst_int_n), .set_i(m_qual), .clr_i(fault_clr),
    .held_o(m_fault_latched));

  gk_latch u_platch (
    .clk(clk), .rst_n(rst_int_n), .set_i(p_src), .clr_i(fault_clr),
    .held_o(p_fault_latched));

  gk_gate #(.NCH(NOUT), .PAIRED(1'b1)) u_mgate (
    .raw(pwm_raw), .act_lvl(out_pol), .kill(m_fault_latched), .pin_out(pwm_gate));

  gk_gate #(.NCH(1), .PAIRED(1'b0)) u_pgate (
    .raw(pfc_raw), .act_lvl(pfc_pol), .kill(p_fault_latched), .pin_out(pfc_gate));
endmodule

// File: rtl/gk_shutdown_chk.sv
module gk_shutdown_chk #(
  parameter int NPH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NPH-1:0] out_pol,
  input logic [2*NPH-1:0] pwm_gate,
  input logic             pfc_pol,
  input logic             pfc_gate,
  input logic             m_fault_latched,
  input logic             p_fault_latched,
  input logic             m_qual,
  input logic             fault_clr
);
  assert_motor_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_fault_latched |-> (pwm_gate == ~out_pol));

  assert_pfc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_fault_latched |-> (pfc_gate == ~pfc_pol));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fault_latched && !fault_clr) |=> m_fault_latched);

  assert_clr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fault_latched && m_qual) |=> m_fault_latched);

  assert_latch_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_qual |=> m_fault_latched);

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_ph
      assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_gate[2*k] == out_pol[2*k]) && (pwm_gate[2*k+1] == out_pol[2*k+1])));
    end
  endgenerate
endmodule

bind gk_shutdown gk_shutdown_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_pol(out_pol), .pwm_gate(pwm_gate),
  .pfc_pol(pfc_pol), .pfc_gate(pfc_gate), .m_fault_latched(m_fault_latched),
  .p_fault_latched(p_fault_latched), .m_qual(m_qual), .fault_clr(fault_clr));

// File: tb/test_gk_shutdown.sv
`timescale 1ns/1ps
module test_gk_shutdown;
  logic       clk, rst_n;
  logic       m_fault_pin, m_sense, p_fault_pin, p_sense;
  logic [7:0] filt_len;
  logic       pfc_route_main;
  logic [5:0] pwm_raw, out_pol;
  logic       pfc_raw, pfc_pol, fault_clr;
  logic [5:0] pwm_gate;
  logic       pfc_gate, m_fault_latched, p_fault_latched;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  gk_shutdown i_gk_shutdown (
    .clk(clk), .rst_n(rst_n), .m_fault_pin(m_fault_pin), .m_sense(m_sense),
    .p_fault_pin(p_fault_pin), .p_sense(p_sense), .filt_len(filt_len),
    .pfc_route_main(pfc_route_main), .pwm_raw(pwm_raw), .out_pol(out_pol),
    .pfc_raw(pfc_raw), .pfc_pol(pfc_pol), .fault_clr(fault_clr),
    .pwm_gate(pwm_gate), .pfc_gate(pfc_gate),
    .m_fault_latched(m_fault_latched), .p_fault_latched(p_fault_latched));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_gate(input logic [5:0] raw, input logic [5:0] pol,
                                          input logic kill);
    logic [5:0] r;
    for (int p = 0; p < 3; p++) begin
      logic both;
      both = raw[2*p] & raw[2*p+1];
      for (int s = 0; s < 2; s++) begin
        logic on;
        on = raw[2*p+s] & ~both & ~kill;
        r[2*p+s] = on ? pol[2*p+s] : ~pol[2*p+s];
      end
    end
    return r;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    m_fault_pin = ~m_sense;
    p_fault_pin = ~p_sense;
    step(6);
    fault_clr = 1'b1;
    step(1);
    fault_clr = 1'b0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; m_sense = 1'b1; p_sense = 1'b1;
    m_fault_pin = 1'b0; p_fault_pin = 1'b0; filt_len = 8'd3;
    pfc_route_main = 1'b0; pwm_raw = 6'b0; out_pol = 6'h3f;
    pfc_raw = 1'b0; pfc_pol = 1'b1; fault_clr = 1'b0;
    step(3);
    #1;
    chk(m_fault_latched == 0 && p_fault_latched == 0, "R11 reset state",
        {m_fault_latched, p_fault_latched}, 0);
    rst_n = 1'b1;
    step(4);

    // R5 / R6: polarity and shoot-through sweep, no fault latched
    for (int pol = 0; pol < 64; pol++) begin
      for (int raw = 0; raw < 64; raw++) begin
        pwm_raw = raw[5:0]; out_pol = pol[5:0];
        #1;
        chk(pwm_gate == exp_gate(raw[5:0], pol[5:0], 1'b0), "R5/R6 gate mapping",
            pwm_gate, exp_gate(raw[5:0], pol[5:0], 1'b0));
      end
      step(1);
    end

    // R1 / R2: pulse length around the threshold, both senses
    for (int sn = 0; sn < 2; sn++) begin
      for (int ni = 0; ni < 4; ni++) begin
        int n;
        n = (ni == 0) ? 1 : (ni == 1) ? 2 : (ni == 2) ? 3 : 5;
        filt_len = n[7:0];
        m_sense = sn[0]; m_fault_pin = ~sn[0];
        step(4);
        for (int k = 0; k <= n + 1; k++) begin
          if (k > 0) begin
            m_fault_pin = sn[0];
            step(k);
            m_fault_pin = ~sn[0];
          end
          step(n + 6);
          #1;
          chk(m_fault_latched == (k >= n), "R1/R2 pulse filter",
              m_fault_latched, (k >= n));
          do_clear();
          chk(m_fault_latched == 0, "R8 clear after pulse", m_fault_latched, 0);
        end
      end
    end

    // filt_len of 0 behaves as 1
    filt_len = 8'd0; m_sense = 1'b1; m_fault_pin = 1'b0;
    step(2);
    m_fault_pin = 1'b1; step(1); m_fault_pin = 1'b0;
    step(6); #1;
    chk(m_fault_latched == 1, "R2 zero length acts as one", m_fault_latched, 1);
    do_clear();

    // R3 / R4 / R7 / R8: latency, forced off level, clear behaviour
    for (int sn = 0; sn < 2; sn++) begin
      for (int n = 1; n <= 6; n += 5) begin
        int lat;
        filt_len = n[7:0];
        m_sense = sn[0]; m_fault_pin = ~sn[0];
        pwm_raw = 6'b100110; out_pol = 6'b011010;
        step(4);
        m_fault_pin = sn[0];
        lat = 0;
        do begin
          step(1); lat++; #1;
        end while (!m_fault_latched && lat < 400);
        chk(lat == n + 3, "R3 latency", lat, n + 3);
        for (int raw = 0; raw < 64; raw++) begin
          pwm_raw = raw[5:0]; out_pol = 6'(raw * 7 + sn);
          #1;
          chk(pwm_gate == ~out_pol, "R4 outputs forced off", pwm_gate, ~out_pol);
        end
        fault_clr = 1'b1; step(1); fault_clr = 1'b0; #1;
        chk(m_fault_latched == 1, "R7 clear ignored while fault held", m_fault_latched, 1);
        m_fault_pin = ~sn[0];
        step(10); #1;
        chk(m_fault_latched == 1, "R7 latch holds after pin idle", m_fault_latched, 1);
        fault_clr = 1'b1; step(1); fault_clr = 1'b0; #1;
        chk(m_fault_latched == 0, "R8 clear accepted", m_fault_latched, 0);
        chk(pwm_gate == exp_gate(pwm_raw, out_pol, 1'b0), "R8 outputs restored",
            pwm_gate, exp_gate(pwm_raw, out_pol, 1'b0));
      end
    end

    // R9: PFC pin with own sense, main fault not routed
    filt_len = 8'd2; m_sense = 1'b1; m_fault_pin = 1'b0;
    pwm_raw = 6'b0; out_pol = 6'h3f;
    for (int sn = 0; sn < 2; sn++) begin
      pfc_route_main = 1'b0; p_sense = sn[0]; p_fault_pin = ~sn[0];
      for (int v = 0; v < 4; v++) begin
        pfc_raw = v[0]; pfc_pol = v[1]; #1;
        chk(pfc_gate == (v[0] ? v[1] : ~v[1]), "R9 pfc polarity", pfc_gate,
            (v[0] ? v[1] : ~v[1]));
      end
      pfc_raw = 1'b1; pfc_pol = sn[0];
      step(4);
      p_fault_pin = sn[0];
      step(5); #1;
      chk(p_fault_latched == 1 && pfc_gate == ~pfc_pol, "R9 pfc shutdown",
          {p_fault_latched, pfc_gate}, {1'b1, ~pfc_pol});
      chk(m_fault_latched == 0, "R9 motor unaffected by pfc pin", m_fault_latched, 0);
      do_clear();
      m_fault_pin = 1'b1; step(8); #1;
      chk(p_fault_latched == 0 && pfc_gate == pfc_pol, "R9 motor fault not routed",
          {p_fault_latched, pfc_gate}, {1'b0, pfc_pol});
      do_clear();
    end

    // R10: routed mode
    pfc_route_main = 1'b1; p_sense = 1'b1; p_fault_pin = 1'b0;
    pfc_raw = 1'b1; pfc_pol = 1'b1;
    step(2);
    p_fault_pin = 1'b1; step(8); #1;
    chk(p_fault_latched == 0 && pfc_gate == 1'b1, "R10 pfc pin ignored",
        {p_fault_latched, pfc_gate}, 2'b01);
    p_fault_pin = 1'b0;
    m_fault_pin = 1'b1; step(5); #1;
    chk(p_fault_latched == 1 && m_fault_latched == 1 && pfc_gate == 1'b0,
        "R10 motor fault kills pfc", {m_fault_latched, p_fault_latched, pfc_gate}, 3'b110);
    do_clear();
    chk(p_fault_latched == 0 && m_fault_latched == 0, "R8 clear both",
        {m_fault_latched, p_fault_latched}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule